// File: doc/BRIEF.md
# Fixed-Period Winding Current Chopper

This block sequences one H-bridge through a current-chopping cycle of fixed length. An external period tick opens each cycle. The bridge then drives the winding in the polarity chosen by the current-sign input. A current-trip comparator flag ends the drive phase, but it is not honoured during an initial blanking window, so the blanking window also acts as the minimum on-time. After the trip, the bridge stays in a decay phase until the next tick. The decay phase is slow (both low sides on, so the current recirculates), fast (the polarity is reversed, and all switches open once a near-zero flag arrives), or mixed. Mixed decay runs fast decay until three quarters of the period have passed and slow decay after that, and it does so only when the indexer marks the present step as a falling-current step. On a rising-current step, mixed decay behaves as slow decay.

The block drives four gate enables: the high and low switch of leg A and of leg B. Each leg has its own dead-time stage, so a switch turns on only after its partner on the same leg has been off for a set number of cycles. An enable input clears all four gates in the same cycle. Once enable returns, no drive begins until the next period tick. The period length, blanking time, mixed-decay switch point and dead time are all parameters counted in system clock cycles. The defaults assume a 50 MHz clock: a 20 µs period, about 3.75 µs of blanking, a switch point at 75 % of the period, and 400 ns of dead time.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is held, and after reset until the first period tick with enable high, all four gate enables are 0.
- R2: A period tick with enable high starts drive. With cur_neg_i=0, leg A is high and leg B is low (gate vector {a_hi,a_lo,b_hi,b_lo} = 1001). With cur_neg_i=1 the legs swap (0110). The two high switches are never on together.
- R3: The trip flag is ignored while the elapsed count is below BLANK_CYC. The elapsed count is 0 in the first cycle after the tick. A trip held from the tick onward ends drive only in the cycle whose count equals BLANK_CYC.
- R4: With decay code 2'b00 (slow), a trip moves the bridge to both low switches on (0101) until the period ends.
- R5: With decay code 2'b10 or 2'b11 (fast), a trip reverses the drive polarity. After that, a near-zero flag opens all switches (0000) until the period ends. The near-zero flag has no effect during drive.
- R6: With decay code 2'b01 (mixed) and cur_decr_i=1, a trip gives fast decay until the elapsed count reaches MIX_CYC, then slow decay. A trip at or after MIX_CYC goes straight to slow decay. With cur_decr_i=0, mixed decay is slow decay.
- R7: Without a trip, drive lasts until the next tick. A tick during decay restarts drive.
- R8: On one leg, the high and low switch are never on together. Either switch turns on only after its partner has been off for at least DEAD_CYC cycles.
- R9: With en_i=0, all gates are 0 in the same cycle and ticks are ignored. After en_i returns to 1, gates stay 0 until the next tick.
- R10: The sign, decay code and direction are taken at the tick. Changes to them later in the same period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; 0 clears all gates at once |
| period_tick_i | input | 1 | One-cycle pulse that opens a chopping period |
| trip_i | input | 1 | Winding current has reached the chopping threshold |
| near_zero_i | input | 1 | Winding current is close to zero |
| decay_sel_i | input | 2 | Decay code: 00 slow, 01 mixed, 10/11 fast |
| cur_neg_i | input | 1 | Sign of the target current (1 = negative) |
| cur_decr_i | input | 1 | Indexer marks the step as falling current |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |

## Verification
The bound checker checks on every cycle that no leg is ever shorted. It also checks that every switch turn-on follows at least DEAD_CYC cycles of its partner being off, that the two high switches never conduct together, and that a low enable clears the gates and keeps them cleared until a tick. Which decay state follows a trip, the blanking boundary, the switch point at 75 % of the period, the near-zero cut-off and the capture of settings at the tick all depend on the period's timing. Only the bench's scenarios show these, by sampling the gate vector at offsets counted from the tick.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DRIVE = 3'd1,
        PH_FAST  = 3'd2,
        PH_SLOW  = 3'd3,
        PH_COAST = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_e;

    typedef struct packed {
        leg_e a;
        leg_e b;
    } bridge_t;

    localparam logic [1:0] DECAY_SLOW  = 2'b00;
    localparam logic [1:0] DECAY_MIXED = 2'b01;

    // Leg states wanted for a chopping phase and current sign.
    function automatic bridge_t bridge_for(input phase_e ph, input logic neg);
        bridge_t r;
        r.a = LEG_OFF;
        r.b = LEG_OFF;
        case (ph)
            PH_DRIVE: begin
                r.a = neg ? LEG_LOW  : LEG_HIGH;
                r.b = neg ? LEG_HIGH : LEG_LOW;
            end
            PH_FAST: begin
                r.a = neg ? LEG_HIGH : LEG_LOW;
                r.b = neg ? LEG_LOW  : LEG_HIGH;
            end
            PH_SLOW: begin
                r.a = LEG_LOW;
                r.b = LEG_LOW;
            end
            default: begin
                r.a = LEG_OFF;
                r.b = LEG_OFF;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chop_elapsed.sv
`timescale 1ns/1ps
// Counts cycles since the last period start; saturates at the period end.
module chop_elapsed #(
    parameter int PERIOD_CYC = 1000,
    parameter int CNT_W      = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] elapsed_o
);

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST_C) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= LAST_C;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign elapsed_o = cnt_q;

endmodule

// File: rtl/chop_seq.sv
`timescale 1ns/1ps
// Phase sequencer: drive, blanking, trip, decay until the next tick.
module chop_seq
    import chop_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int BLANK_CYC = 188,
    parameter int MIX_CYC   = 750
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             trip_i,
    input  logic             near_zero_i,
    input  logic [1:0]       decay_sel_i,
    input  logic             cur_neg_i,
    input  logic             cur_decr_i,
    input  logic [CNT_W-1:0] elapsed_i,
    output logic             restart_o,
    output phase_e           phase_o,
    output logic             neg_o
);

    localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] MIX_C   = CNT_W'(MIX_CYC);

    typedef struct packed {
        phase_e     ph;
        logic       neg;
        logic [1:0] mode;
        logic       decr;
    } seq_t;

    seq_t   seq_d, seq_q;
    phase_e entry_ph;
    logic   past_blank, past_mix, mixed_q;

    assign past_blank = (elapsed_i >= BLANK_C);
    assign past_mix   = (elapsed_i >= MIX_C);
    assign mixed_q    = (seq_q.mode == DECAY_MIXED);

    // Decay phase entered on a trip, from the settings taken at the tick.
    always_comb begin
        if (seq_q.mode[1]) begin
            entry_ph = PH_FAST;
        end else if (mixed_q && seq_q.decr && !past_mix) begin
            entry_ph = PH_FAST;
        end else begin
            entry_ph = PH_SLOW;
        end
    end

    always_comb begin
        seq_d = seq_q;
        if (!en_i) begin
            seq_d.ph = PH_IDLE;
        end else if (tick_i) begin
            seq_d.ph   = PH_DRIVE;
            seq_d.neg  = cur_neg_i;
            seq_d.mode = decay_sel_i;
            seq_d.decr = cur_decr_i;
        end else begin
            case (seq_q.ph)
                PH_DRIVE: begin
                    if (trip_i && past_blank) begin
                        seq_d.ph = entry_ph;
                    end
                end
                PH_FAST: begin
                    if (near_zero_i) begin
                        seq_d.ph = PH_COAST;
                    end else if (mixed_q && past_mix) begin
                        seq_d.ph = PH_SLOW;
                    end
                end
                default: begin
                    seq_d.ph = seq_q.ph;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{ph: PH_IDLE, neg: 1'b0, mode: DECAY_SLOW, decr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign restart_o = en_i && tick_i;
    assign phase_o   = seq_q.ph;
    assign neg_o     = seq_q.neg;

endmodule

// File: rtl/chop_dead_leg.sv
`timescale 1ns/1ps
// One half-bridge leg with break-before-make dead time.
module chop_dead_leg
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  leg_e want_i,
    output logic hi_o,
    output logic lo_o
);

    localparam int              DW      = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0]   DMAX_C  = DW'(DEAD_CYC);
    localparam logic [DW-1:0]   DLAST_C = DW'(DEAD_CYC - 1);

    typedef struct packed {
        leg_e          cur;
        leg_e          last;
        logic [DW-1:0] cnt;
    } leg_t;

    leg_t leg_d, leg_q;
    logic allow_on;

    // A side may turn on when it matches the last driven side or the gap is long enough.
    assign allow_on = (leg_q.last == LEG_OFF) || (leg_q.last == want_i) ||
                      (leg_q.cnt >= DLAST_C);

    always_comb begin
        leg_d = leg_q;
        if (leg_q.cur != LEG_OFF) begin
            if (!en_i || (want_i != leg_q.cur)) begin
                leg_d.cur  = LEG_OFF;
                leg_d.last = leg_q.cur;
                leg_d.cnt  = '0;
            end
        end else begin
            if (en_i && (want_i != LEG_OFF) && allow_on) begin
                leg_d.cur = want_i;
            end else if (leg_q.cnt < DMAX_C) begin
                leg_d.cnt = leg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            leg_q <= '{cur: LEG_OFF, last: LEG_OFF, cnt: DMAX_C};
        end else begin
            leg_q <= leg_d;
        end
    end

    assign hi_o = en_i && (leg_q.cur == LEG_HIGH);
    assign lo_o = en_i && (leg_q.cur == LEG_LOW);

endmodule

// File: rtl/chop_ctrl.sv
`timescale 1ns/1ps
// Fixed-period current-chopping controller for one H-bridge.
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 1000,
    parameter int BLANK_CYC  = 188,
    parameter int MIX_CYC    = (PERIOD_CYC * 3) / 4,
    parameter int DEAD_CYC   = 20
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       period_tick_i,
    input  logic       trip_i,
    input  logic       near_zero_i,
    input  logic [1:0] decay_sel_i,
    input  logic       cur_neg_i,
    input  logic       cur_decr_i,
    output logic       a_hi_o,
    output logic       a_lo_o,
    output logic       b_hi_o,
    output logic       b_lo_o
);

    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int NLEG  = 2;

    logic [CNT_W-1:0] elapsed;
    logic             restart;
    phase_e           phase;
    logic             neg;
    bridge_t          want;
    leg_e             want_leg [NLEG];
    logic             leg_hi   [NLEG];
    logic             leg_lo   [NLEG];

    chop_elapsed #(
        .PERIOD_CYC (PERIOD_CYC),
        .CNT_W      (CNT_W)
    ) i_elapsed (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .elapsed_o (elapsed)
    );

    chop_seq #(
        .CNT_W     (CNT_W),
        .BLANK_CYC (BLANK_CYC),
        .MIX_CYC   (MIX_CYC)
    ) i_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .tick_i      (period_tick_i),
        .trip_i      (trip_i),
        .near_zero_i (near_zero_i),
        .decay_sel_i (decay_sel_i),
        .cur_neg_i   (cur_neg_i),
        .cur_decr_i  (cur_decr_i),
        .elapsed_i   (elapsed),
        .restart_o   (restart),
        .phase_o     (phase),
        .neg_o       (neg)
    );

    assign want        = bridge_for(phase, neg);
    assign want_leg[0] = want.a;
    assign want_leg[1] = want.b;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        chop_dead_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) i_leg (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (en_i),
            .want_i (want_leg[g]),
            .hi_o   (leg_hi[g]),
            .lo_o   (leg_lo[g])
        );
    end

    assign a_hi_o = leg_hi[0];
    assign a_lo_o = leg_lo[0];
    assign b_hi_o = leg_hi[1];
    assign b_lo_o = leg_lo[1];

endmodule

// File: rtl/chop_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to chop_ctrl.
module chop_ctrl_chk #(
    parameter int DEAD_CYC = 20
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic tick_i,
    input logic a_hi_i,
    input logic a_lo_i,
    input logic b_hi_i,
    input logic b_lo_i
);

    localparam int             CW     = $clog2(DEAD_CYC + 2);
    localparam logic [CW-1:0]  SAT_C  = CW'(DEAD_CYC);

    logic [3:0]    gates;
    logic [CW-1:0] off_cnt [4];

    assign gates = {a_hi_i, a_lo_i, b_hi_i, b_lo_i};

    // Cycles each switch has been off, saturating at the dead time.
    for (genvar i = 0; i < 4; i++) begin : g_off
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                off_cnt[i] <= SAT_C;
            end else if (gates[i]) begin
                off_cnt[i] <= '0;
            end else if (off_cnt[i] < SAT_C) begin
                off_cnt[i] <= off_cnt[i] + 1'b1;
            end
        end

        AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(gates[i]) |-> (off_cnt[i ^ 1] >= SAT_C)); // R8
    end

    AST_NO_SHOOT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(a_hi_i && a_lo_i)); // R8
    AST_NO_SHOOT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(b_hi_i && b_lo_i)); // R8
    AST_NO_DOUBLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(a_hi_i && b_hi_i)); // R2
    AST_GATES_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (gates == 4'b0000)); // R9
    AST_OFF_AFTER_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (gates == 4'b0000)); // R9
    AST_WAIT_FOR_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i ##1 (en_i && !tick_i)) |=> (gates == 4'b0000)); // R9

endmodule

bind chop_ctrl chop_ctrl_chk #(
    .DEAD_CYC (DEAD_CYC)
) i_chop_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (period_tick_i),
    .a_hi_i (a_hi_o),
    .a_lo_i (a_lo_o),
    .b_hi_i (b_hi_o),
    .b_lo_i (b_lo_o)
);

// File: tb/test_chop_ctrl.sv
`timescale 1ns/1ps
module test_chop_ctrl;

    // Shortened timing: period 40, blanking 6, mixed switch 30, dead time 2.
    localparam int PER   = 40;
    localparam int BLANK = 6;
    localparam int MIX   = 30;
    localparam int DEAD  = 2;
    localparam int NEVER = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       trip = 1'b0;
    logic       zero = 1'b0;
    logic [1:0] dsel = 2'b00;
    logic       neg = 1'b0;
    logic       decr = 1'b0;
    logic       a_hi, a_lo, b_hi, b_lo;
    logic [3:0] gates;

    int n_chk = 0;
    int n_bad = 0;
    int off = 0;
    int trip_at = NEVER;
    int zero_at = NEVER;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign gates = {a_hi, a_lo, b_hi, b_lo};

    chop_ctrl #(
        .PERIOD_CYC (PER),
        .BLANK_CYC  (BLANK),
        .MIX_CYC    (MIX),
        .DEAD_CYC   (DEAD)
    ) i_chop_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .en_i          (en),
        .period_tick_i (tick),
        .trip_i        (trip),
        .near_zero_i   (zero),
        .decay_sel_i   (dsel),
        .cur_neg_i     (neg),
        .cur_decr_i    (decr),
        .a_hi_o        (a_hi),
        .a_lo_o        (a_lo),
        .b_hi_o        (b_hi),
        .b_lo_o        (b_lo)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       sgn;
        logic       dec;
        logic [7:0] trip_off;
        logic [7:0] zero_off;
        logic [7:0] samp;
        logic [3:0] expv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    // Gate vector {a_hi,a_lo,b_hi,b_lo}; offsets count cycles after the tick edge.
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 8'd10,  8'd255, 8'd5,  4'b1001, 8'd2},  // R2 positive drive
        '{2'b00, 1'b1, 1'b0, 8'd10,  8'd255, 8'd5,  4'b0110, 8'd2},  // R2 negative drive
        '{2'b00, 1'b0, 1'b0, 8'd10,  8'd255, 8'd12, 4'b0001, 8'd8},  // R8 leg A gap
        '{2'b00, 1'b0, 1'b0, 8'd10,  8'd255, 8'd14, 4'b0101, 8'd4},  // R4 slow decay
        '{2'b00, 1'b1, 1'b0, 8'd10,  8'd255, 8'd14, 4'b0101, 8'd4},  // R4 slow, negative
        '{2'b00, 1'b1, 1'b0, 8'd10,  8'd255, 8'd13, 4'b0100, 8'd8},  // R8 leg B gap
        '{2'b10, 1'b0, 1'b0, 8'd10,  8'd255, 8'd13, 4'b0000, 8'd8},  // R8 both legs gap
        '{2'b10, 1'b0, 1'b0, 8'd10,  8'd255, 8'd14, 4'b0110, 8'd5},  // R5 fast reverses
        '{2'b10, 1'b1, 1'b0, 8'd10,  8'd255, 8'd14, 4'b1001, 8'd5},  // R5 fast, negative
        '{2'b10, 1'b0, 1'b0, 8'd10,  8'd20,  8'd21, 4'b0110, 8'd5},  // R5 before zero seen
        '{2'b10, 1'b0, 1'b0, 8'd10,  8'd20,  8'd22, 4'b0000, 8'd5},  // R5 coast at zero
        '{2'b11, 1'b0, 1'b0, 8'd10,  8'd255, 8'd14, 4'b0110, 8'd5},  // R5 code 11 is fast
        '{2'b01, 1'b0, 1'b1, 8'd10,  8'd255, 8'd29, 4'b0110, 8'd6},  // R6 fast part
        '{2'b01, 1'b0, 1'b1, 8'd10,  8'd255, 8'd32, 4'b0100, 8'd6},  // R6 switching
        '{2'b01, 1'b0, 1'b1, 8'd10,  8'd255, 8'd34, 4'b0101, 8'd6},  // R6 slow part
        '{2'b01, 1'b0, 1'b0, 8'd10,  8'd255, 8'd14, 4'b0101, 8'd6},  // R6 rising -> slow
        '{2'b01, 1'b0, 1'b1, 8'd32,  8'd255, 8'd34, 4'b0001, 8'd6},  // R6 late trip
        '{2'b01, 1'b0, 1'b1, 8'd32,  8'd255, 8'd36, 4'b0101, 8'd6},  // R6 late trip slow
        '{2'b00, 1'b0, 1'b0, 8'd0,   8'd255, 8'd7,  4'b1001, 8'd3},  // R3 blanked trip
        '{2'b00, 1'b0, 1'b0, 8'd0,   8'd255, 8'd8,  4'b0001, 8'd3},  // R3 trip honoured
        '{2'b00, 1'b0, 1'b0, 8'd255, 8'd255, 8'd38, 4'b1001, 8'd7},  // R7 no trip
        '{2'b10, 1'b0, 1'b0, 8'd255, 8'd0,   8'd20, 4'b1001, 8'd5}   // R5 zero during drive
    };

    task automatic check(input logic [3:0] expv, input string tag);
        n_chk++;
        if (gates !== expv) begin
            n_bad++;
            $display("FAIL %s: gates=%b expected=%b", tag, gates, expv);
        end
    endtask

    task automatic start_period(input logic [1:0] m, input logic s, input logic d,
                                input int ta, input int za);
        @(negedge clk);
        en = 1'b0; tick = 1'b0; trip = 1'b0; zero = 1'b0;
        repeat (4) @(negedge clk);
        en = 1'b1; tick = 1'b1; dsel = m; neg = s; decr = d;
        trip_at = ta; zero_at = za; off = -1;
    endtask

    task automatic adv_to(input int k);
        while (off < k) begin
            @(negedge clk);
            off++;
            tick = 1'b0;
            trip = (off >= trip_at);
            zero = (off >= zero_at);
        end
    endtask

    initial begin
        // R1: reset state
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(4'b0000, "R1 during reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(4'b0000, "R1 no tick after reset");

        for (int i = 0; i < NV; i++) begin
            start_period(VECS[i].mode, VECS[i].sgn, VECS[i].dec,
                         (VECS[i].trip_off == 8'd255) ? NEVER : int'(VECS[i].trip_off),
                         (VECS[i].zero_off == 8'd255) ? NEVER : int'(VECS[i].zero_off));
            adv_to(int'(VECS[i].samp));
            check(VECS[i].expv, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R9: disable clears gates at once and ignores ticks
        start_period(2'b00, 1'b0, 1'b0, NEVER, NEVER);
        adv_to(5);
        check(4'b1001, "R9 drive before disable");
        en = 1'b0;
        #1;
        check(4'b0000, "R9 same-cycle disable");
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
        check(4'b0000, "R9 tick ignored while disabled");
        en = 1'b1;
        repeat (5) @(negedge clk);
        check(4'b0000, "R9 waits for tick");
        tick = 1'b1; trip_at = NEVER; zero_at = NEVER; off = -1;
        adv_to(2);
        check(4'b1001, "R9 resumes on tick");

        // R10: settings captured at the tick
        start_period(2'b00, 1'b0, 1'b0, 10, NEVER);
        adv_to(3);
        neg = 1'b1; dsel = 2'b10;
        adv_to(5);
        check(4'b1001, "R10 sign change ignored");
        adv_to(14);
        check(4'b0101, "R10 decay code change ignored");

        // R7: tick during slow decay restarts drive
        start_period(2'b00, 1'b0, 1'b0, 10, NEVER);
        neg = 1'b0;
        adv_to(39);
        tick = 1'b1; trip_at = NEVER; trip = 1'b0;
        adv_to(41);
        check(4'b0001, "R7 restart gap");
        adv_to(43);
        check(4'b1001, "R7 restart drive");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule